// File: doc/BRIEF.md
# Multi-Format Three-Wire Radio Register Writer

This block sends one register write to a radio synthesizer over a three-wire serial link. The link has a serial clock, a serial data line and an active-low enable that also latches the frame. The host gives a radio type code, an address and a value, and pulses `start` for one cycle. The radio type sets the frame length, the bit order and how address and data are packed into the frame. The block then generates the whole serial sequence. When it finishes it pulses `done`. A type code it does not support gives a one-cycle `err` and no activity on the link.

The controller is one state machine with seven states. `S_IDLE` waits for `start`. It moves to `S_SETUP` when the type is supported, and to `S_ERR` when it is not. `S_SETUP` pulls enable low while clock stays low. `S_DRIVE` puts the current bit on the data line with clock low. `S_HIGH` raises the clock. `S_HIGH` returns to `S_DRIVE` for the next bit, or goes to `S_TAIL` after the final bit. `S_TAIL` keeps enable low for one last low phase. `S_DONE` raises enable, which latches the frame, and pulses `done`. `S_DONE` and `S_ERR` both return to `S_IDLE` after one cycle. The field widths are parameters. The clock-high phase and the clock-low phase each last a parameterised number of system clock cycles.

Top module: `rf3w_writer`

## Requirements
- R1: Type code 0 sends a 16-bit frame, most significant bit first. Frame bits [15:12] hold address bits [3:0], and frame bits [11:0] hold value bits [11:0].
- R2: Type code 1 sends a 32-bit frame, least significant bit first. Frame bits [19:0] hold value bits [19:0], and frame bits [26:20] hold address bits [6:0]. Frame bit 27 is a write-enable bit and is always 1. Frame bits [31:28] are 0.
- R3: Type codes 2 and 3 each send a 22-bit frame, most significant bit first. Frame bits [21:17] hold address bits [4:0], and frame bits [16:0] hold value bits [16:0].
- R4: Type codes 4 to 7 are unsupported. On such a code, `err` is 1 for exactly one cycle, starting one cycle after `start`. The link shows no clock edge, and enable stays high.
- R5: After reset and whenever the block is idle, `sen_n` is 1, `sclk` is 0, `busy` is 0, and `done` and `err` are 0.
- R6: Enable goes low with clock low. It stays low through 2*LOW_CYC cycles before the first rising clock edge, and it is low at every rising clock edge.
- R7: Every clock-high phase lasts exactly HIGH_CYC cycles. The clock-low gap between two bits lasts exactly LOW_CYC cycles.
- R8: The data line does not change while the clock is high.
- R9: After the last falling clock edge, enable stays low for LOW_CYC cycles. It then rises in the same cycle as a single one-cycle `done` pulse, and the block returns to idle.
- R10: A `start` that arrives while `busy` is 1 is ignored. The current frame is sent unchanged, and no second frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to send a write |
| radio_type | input | 3 | Radio type code, sampled with start |
| addr | input | ADDR_W | Register address, sampled with start |
| value | input | FRAME_W | Register value, sampled with start |
| sclk | output | 1 | Serial clock |
| sdata | output | 1 | Serial data |
| sen_n | output | 1 | Active-low enable; its rising edge latches the frame |
| busy | output | 1 | A write or error response is in progress |
| done | output | 1 | One-cycle pulse when the frame has been latched |
| err | output | 1 | One-cycle pulse for an unsupported type code |

## Verification
The bench builds the block with HIGH_CYC=3 and LOW_CYC=2. Because the two phase lengths differ, a high phase and a low phase swapped with each other shows up in the measured run lengths. The setup gap of 2*LOW_CYC also differs from the gap of LOW_CYC between bits. These short phases keep a full 32-bit frame to about 170 cycles. That leaves room for back-to-back writes, an overlapping start and error recovery in one run. Each captured frame is rebuilt from data sampled on each rising serial clock edge, and is compared both in bit count and in bit order.

// File: rtl/rf3w_pkg.sv
package rf3w_pkg;
    localparam logic [2:0] RT_A = 3'd0;
    localparam logic [2:0] RT_B = 3'd1;
    localparam logic [2:0] RT_C = 3'd2;
    localparam logic [2:0] RT_D = 3'd3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_DRIVE,
        S_HIGH,
        S_TAIL,
        S_DONE,
        S_ERR
    } wr_state_e;
endpackage

// File: rtl/rf3w_framer.sv
module rf3w_framer
    import rf3w_pkg::*;
#(
    parameter int FRAME_W = 32,
    parameter int ADDR_W  = 8,
    parameter int A_DW    = 12,
    parameter int A_AW    = 4,
    parameter int B_DW    = 20,
    parameter int B_AW    = 7,
    parameter int C_DW    = 17,
    parameter int C_AW    = 5,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic [2:0]         rtype,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [FRAME_W-1:0] value,
    output logic [FRAME_W-1:0] frame_aligned,
    output logic [CNT_W-1:0]   nbits,
    output logic               lsb_first,
    output logic               supported
);
    localparam int A_LEN = A_DW + A_AW;
    localparam int B_LEN = FRAME_W;
    localparam int C_LEN = C_DW + C_AW;
    localparam int B_WEN = B_DW + B_AW;
    localparam logic [FRAME_W-1:0] ONES = '1;
    localparam logic [FRAME_W-1:0] A_DM = ONES >> (FRAME_W - A_DW);
    localparam logic [FRAME_W-1:0] A_AM = ONES >> (FRAME_W - A_AW);
    localparam logic [FRAME_W-1:0] B_DM = ONES >> (FRAME_W - B_DW);
    localparam logic [FRAME_W-1:0] B_AM = ONES >> (FRAME_W - B_AW);
    localparam logic [FRAME_W-1:0] C_DM = ONES >> (FRAME_W - C_DW);
    localparam logic [FRAME_W-1:0] C_AM = ONES >> (FRAME_W - C_AW);

    logic [FRAME_W-1:0] addr_x;
    logic [FRAME_W-1:0] raw;

    assign addr_x = FRAME_W'(addr);

    always_comb begin
        raw       = '0;
        nbits     = '0;
        lsb_first = 1'b0;
        supported = 1'b1;
        unique case (rtype)
            RT_A: begin
                raw   = ((addr_x & A_AM) << A_DW) | (value & A_DM);
                nbits = CNT_W'(A_LEN);
            end
            RT_B: begin
                raw       = ((addr_x & B_AM) << B_DW) | (value & B_DM)
                          | (FRAME_W'(1) << B_WEN);
                nbits     = CNT_W'(B_LEN);
                lsb_first = 1'b1;
            end
            RT_C, RT_D: begin
                raw   = ((addr_x & C_AM) << C_DW) | (value & C_DM);
                nbits = CNT_W'(C_LEN);
            end
            default: supported = 1'b0;
        endcase
        // MSB-first frames are left-aligned so the shifter always takes the top bit
        frame_aligned = lsb_first ? raw : (raw << (CNT_W'(FRAME_W) - nbits));
    end
endmodule

// File: rtl/rf3w_phase_timer.sv
module rf3w_phase_timer #(
    parameter int HIGH_CYC = 4,
    parameter int LOW_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic sel_high,
    output logic expired
);
    localparam int MAX_CYC = (HIGH_CYC > LOW_CYC) ? HIGH_CYC : LOW_CYC;
    localparam int TW      = $clog2(MAX_CYC + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= sel_high ? TW'(HIGH_CYC - 1) : TW'(LOW_CYC - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/rf3w_shifter.sv
module rf3w_shifter #(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               shift,
    input  logic               lsb_first,
    input  logic [FRAME_W-1:0] frame,
    output logic               bit_out
);
    logic [FRAME_W-1:0] sr;
    logic               dir_lsb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr      <= '0;
            dir_lsb <= 1'b0;
        end else if (load) begin
            sr      <= frame;
            dir_lsb <= lsb_first;
        end else if (shift) begin
            sr <= dir_lsb ? (sr >> 1) : (sr << 1);
        end
    end

    assign bit_out = dir_lsb ? sr[0] : sr[FRAME_W-1];
endmodule

// File: rtl/rf3w_writer.sv
module rf3w_writer
    import rf3w_pkg::*;
#(
    parameter int FRAME_W  = 32,
    parameter int ADDR_W   = 8,
    parameter int A_DW     = 12,
    parameter int A_AW     = 4,
    parameter int B_DW     = 20,
    parameter int B_AW     = 7,
    parameter int C_DW     = 17,
    parameter int C_AW     = 5,
    parameter int HIGH_CYC = 4,
    parameter int LOW_CYC  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [2:0]         radio_type,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [FRAME_W-1:0] value,
    output logic               sclk,
    output logic               sdata,
    output logic               sen_n,
    output logic               busy,
    output logic               done,
    output logic               err
);
    localparam int CNT_W = $clog2(FRAME_W + 1);

    wr_state_e          state, state_n;
    logic [FRAME_W-1:0] frame_aligned;
    logic [CNT_W-1:0]   nbits, bits_left;
    logic               lsb_first, supported;
    logic               expired, bit_out;
    logic               accept, advance;

    rf3w_framer #(
        .FRAME_W(FRAME_W), .ADDR_W(ADDR_W),
        .A_DW(A_DW), .A_AW(A_AW), .B_DW(B_DW), .B_AW(B_AW),
        .C_DW(C_DW), .C_AW(C_AW), .CNT_W(CNT_W)
    ) u_framer (
        .rtype(radio_type), .addr(addr), .value(value),
        .frame_aligned(frame_aligned), .nbits(nbits),
        .lsb_first(lsb_first), .supported(supported)
    );

    rf3w_phase_timer #(.HIGH_CYC(HIGH_CYC), .LOW_CYC(LOW_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .load(state_n != state), .sel_high(state_n == S_HIGH),
        .expired(expired)
    );

    rf3w_shifter #(.FRAME_W(FRAME_W)) u_shifter (
        .clk(clk), .rst_n(rst_n),
        .load(accept), .shift(advance),
        .lsb_first(lsb_first), .frame(frame_aligned),
        .bit_out(bit_out)
    );

    assign accept  = (state == S_IDLE) && start && supported;
    assign advance = (state == S_HIGH) && (state_n == S_DRIVE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            bits_left <= '0;
        end else begin
            state <= state_n;
            if (accept)       bits_left <= nbits;
            else if (advance) bits_left <= bits_left - 1'b1;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:  if (start) state_n = supported ? S_SETUP : S_ERR;
            S_SETUP: if (expired) state_n = S_DRIVE;
            S_DRIVE: if (expired) state_n = S_HIGH;
            S_HIGH:  if (expired) state_n = (bits_left == CNT_W'(1)) ? S_TAIL : S_DRIVE;
            S_TAIL:  if (expired) state_n = S_DONE;
            S_DONE:  state_n = S_IDLE;
            S_ERR:   state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    always_comb begin
        sclk  = (state == S_HIGH);
        sen_n = !((state == S_SETUP) || (state == S_DRIVE) ||
                  (state == S_HIGH)  || (state == S_TAIL));
        sdata = ((state == S_DRIVE) || (state == S_HIGH)) && bit_out;
        busy  = (state != S_IDLE);
        done  = (state == S_DONE);
        err   = (state == S_ERR);
    end

    // R8
    sdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdata));

    // R6
    edge_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> !sen_n);

    // R4
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (sen_n && !sclk));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R5
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sen_n && !sclk && !done && !err));

    // R9
    latch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sen_n) |-> done);
endmodule

// File: tb/rf3w_writer_tb.sv
`timescale 1ns/1ps
module rf3w_writer_tb;
    localparam int HC = 3;
    localparam int LC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  radio_type = '0;
    logic [7:0]  addr = '0;
    logic [31:0] value = '0;
    logic        sclk, sdata, sen_n, busy, done, err;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic cap [0:63];
    int   ncap = 0;
    int   ndone = 0;
    int   hi_run = 0;
    int   lo_run = 0;
    bit   first_edge = 1;
    logic prev_sen_n = 1'b1;

    always #2 clk = ~clk;

    rf3w_writer #(.HIGH_CYC(HC), .LOW_CYC(LC)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .radio_type(radio_type),
        .addr(addr), .value(value), .sclk(sclk), .sdata(sdata),
        .sen_n(sen_n), .busy(busy), .done(done), .err(err)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge sclk) begin
        if (ncap < 64) cap[ncap] = sdata;
        ncap++;
        check(sen_n == 1'b0, "R6 enable low at rising edge", sen_n, 0);
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (done) ndone++;
            if (sclk) begin
                if (hi_run == 0) begin
                    check(lo_run == (first_edge ? 2*LC : LC),
                          first_edge ? "R6 setup gap" : "R7 low gap", lo_run,
                          first_edge ? 2*LC : LC);
                    first_edge = 0;
                end
                hi_run++;
                lo_run = 0;
            end else begin
                if (hi_run != 0) check(hi_run == HC, "R7 high phase", hi_run, HC);
                hi_run = 0;
                if (!sen_n) lo_run++;
            end
            if (!prev_sen_n && sen_n) begin
                check(lo_run == LC, "R9 tail before latch", lo_run, LC);
                check(done == 1'b1, "R9 done with latch", done, 1);
            end
            if (sen_n) begin
                lo_run = 0;
                first_edge = 1;
            end
            prev_sen_n = sen_n;
        end
    end

    function automatic logic [31:0] exp_frame(input logic [2:0] t, input logic [7:0] a, input logic [31:0] v);
        case (t)
            3'd0:    return {16'h0, a[3:0], v[11:0]};
            3'd1:    return {4'h0, 1'b1, a[6:0], v[19:0]};
            default: return {10'h0, a[4:0], v[16:0]};
        endcase
    endfunction

    task automatic pulse_start(input logic [2:0] t, input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        radio_type = t; addr = a; value = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end(output bit got_done);
        got_done = 0;
        for (int i = 0; i < 1000; i++) begin
            if (done) begin got_done = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic run_write(input logic [2:0] t, input logic [7:0] a, input logic [31:0] v, input string req);
        int len;
        bit lsb, got;
        logic [31:0] frm, e;
        len = (t == 3'd0) ? 16 : (t == 3'd1) ? 32 : 22;
        lsb = (t == 3'd1);
        ncap = 0;
        pulse_start(t, a, v);
        wait_end(got);
        check(got, {req, " done seen"}, got, 1);
        check(ncap == len, {req, " bit count"}, ncap, len);
        frm = '0;
        for (int i = 0; i < len && i < 64; i++) begin
            if (lsb) frm[i] = cap[i];
            else     frm = {frm[30:0], cap[i]};
        end
        e = exp_frame(t, a, v);
        check(frm == e, {req, " frame order"}, frm, e);
        @(negedge clk);
        check(!done && !busy && sen_n && !sclk, "R9 return to idle", {done, busy, sen_n, sclk}, 4'b0010);
    endtask

    task automatic t_reset();
        check(sen_n == 1'b1 && sclk == 1'b0, "R5 reset lines", {sen_n, sclk}, 2'b10);
        check(!busy && !done && !err, "R5 reset status", {busy, done, err}, 0);
    endtask

    task automatic t_bad_type(input logic [2:0] t);
        int c0, d0;
        c0 = ncap; d0 = ndone;
        pulse_start(t, 8'hFF, 32'hFFFF_FFFF);
        check(err == 1'b1 && sen_n == 1'b1, "R4 err pulse", {err, sen_n}, 2'b11);
        @(negedge clk);
        check(err == 1'b0 && !busy, "R4 err one cycle", {err, busy}, 0);
        repeat (20) @(negedge clk);
        check(ncap == c0 && ndone == d0 && sen_n, "R4 no link activity", ncap - c0, 0);
    endtask

    task automatic t_busy_start();
        int d0, c1;
        bit got;
        logic [31:0] frm;
        d0 = ndone;
        ncap = 0;
        pulse_start(3'd0, 8'h0A, 32'h0000_0C35);
        repeat (10) @(negedge clk);
        pulse_start(3'd1, 8'h55, 32'hAAAA_AAAA);
        wait_end(got);
        frm = '0;
        for (int i = 0; i < 16; i++) frm = {frm[30:0], cap[i]};
        check(ncap == 16 && frm == exp_frame(3'd0, 8'h0A, 32'h0000_0C35),
              "R10 frame unchanged", frm, exp_frame(3'd0, 8'h0A, 32'h0000_0C35));
        c1 = ncap;
        repeat (200) @(negedge clk);
        check(ncap == c1 && ndone == d0 + 1 && !busy, "R10 no second frame", ndone - d0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        run_write(3'd0, 8'h0B, 32'h0000_0A5C, "R1 typeA pattern1");
        run_write(3'd0, 8'hF1, 32'hFFFF_F001, "R1 typeA pattern2");
        run_write(3'd1, 8'h4D, 32'h000C_3A97, "R2 typeB pattern1");
        run_write(3'd1, 8'hFF, 32'hFFF0_0001, "R2 typeB pattern2");
        run_write(3'd2, 8'h13, 32'h0001_6E2B, "R3 typeC");
        run_write(3'd3, 8'hEA, 32'hFFFE_0F0F, "R3 typeD");
        t_bad_type(3'd5);
        t_bad_type(3'd7);
        run_write(3'd0, 8'h06, 32'h0000_0123, "R4 recovery after err");
        t_busy_start();
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule